// File: doc/BRIEF.md
# Cycle-Qualified Chip-Select Decoder

This block produces the chip selects for a 24-bit address space behind an 8-bit processor that labels every bus cycle with two status bits: a data-address-valid flag and a program-address-valid flag. It splits the space into three regions: an I/O window, a code ROM and general RAM. Each region's read select is gated by a different mix of the two flags. Reads on internal cycles, where the address may be garbage, never reach a device. Devices whose registers change state when read are therefore safe from dummy accesses. One example is the early access of an indexed read, which can land 0x100 below the intended address.

Writes need no status qualification, because the address is always valid while the write strobe is active. An opcode fetch aimed at the I/O window selects nothing. Instead the block asks the data bus to carry a fixed 0x00. An optional filter watches opcode bytes fetched from memory. When one of them is on a forbidden list, the filter replaces it with a no-operation byte and latches a sticky violation flag. All selects are gated with the phase-2 clock level. The violation flag is registered on the system clock `clk`.

Top module: `bus_qualifier`

## Requirements
- R1: A read cycle with both status flags low (code 00, internal cycle) asserts none of `ram_cs`, `rom_cs`, `io_cs`, `subst_en`. This covers an indexed read's early access at the address 0x100 below its target, for example 0x00D0xx ahead of an I/O access at 0x00D1xx.
- R2: A write cycle (`rw_n` = 0) with `phi2` high asserts the select of the addressed region whatever the status flags are, including code 00.
- R3: A read in the I/O window asserts `io_cs` only when the data flag is 1 and the program flag is 0 (code 10). Codes 00, 01 and 11 leave it low.
- R4: A read in the ROM or RAM region asserts that region's select when at least one status flag is high (codes 01, 10, 11).
- R5: An opcode fetch (both flags high, read, `phi2` high) in the I/O window asserts no select, drives `subst_en` high and sets `subst_byte` to 0x00, whether or not the filter is enabled.
- R6: While `phi2` is low, all three selects and `subst_en` are low.
- R7: Region decode: the I/O window is 0x00D100 to 0x00D1FF, the ROM is 0x00E000 to 0x00FFFF, and every other address is RAM. At most one select is high at any time. `subst_byte` is 0x00 whenever `subst_en` is low.
- R8: With `filter_en` high, an opcode fetch outside the I/O window whose `fetch_byte` is 0xDB or 0x42 drives `subst_en` high with `subst_byte` = 0xEA, and the region select stays asserted. With `filter_en` low, on any non-fetch cycle, or for any other byte, nothing is substituted.
- R9: `bad_fetch` is 0 after reset. It becomes 1 at the first `clk` rising edge that sees an R8 substitution, and it stays 1 until reset. Fetches blocked by R5 do not set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for the violation flag |
| rst_n | input | 1 | Asynchronous active-low reset |
| phi2 | input | 1 | Processor phase-2 clock level |
| addr | input | 24 | Processor address bus |
| rw_n | input | 1 | 1 = read, 0 = write |
| data_valid | input | 1 | Cycle carries a valid data address |
| prog_valid | input | 1 | Cycle carries a valid program address |
| filter_en | input | 1 | Enables the forbidden-opcode filter |
| fetch_byte | input | 8 | Byte returned by the selected memory |
| ram_cs | output | 1 | RAM select, active high |
| rom_cs | output | 1 | ROM select, active high |
| io_cs | output | 1 | I/O window select, active high |
| subst_en | output | 1 | Data bus must carry `subst_byte` instead of memory |
| subst_byte | output | 8 | Byte forced onto the data bus |
| bad_fetch | output | 1 | Sticky forbidden-opcode flag |

## Verification
The selects, `subst_en` and `subst_byte` are combinational, so each one is due in the same cycle its inputs are applied. `bad_fetch` is due one `clk` rising edge after the offending fetch. The bench drives stimulus on the falling edge of `clk` and samples 1 ns later, so that sample shows the combinational results of the current inputs. The flag seen at that sample reflects only earlier rising edges, so the model sets its expected flag for the cycle after the violating one. The sweep covers every status code, both transfer directions and both `phi2` levels at addresses on each side of each region boundary.

// File: rtl/bus_qualifier.sv
module bus_qualifier #(
  parameter int AW = 24,
  parameter logic [AW-1:0] IO_BASE = 24'h00D100,
  parameter int IO_SPAN_BITS = 8,
  parameter logic [AW-1:0] ROM_BASE = 24'h00E000,
  parameter int ROM_SPAN_BITS = 13,
  parameter logic [7:0] NOP_CODE = 8'hEA,
  parameter logic [7:0] IO_FETCH_CODE = 8'h00,
  parameter int NUM_BAD = 2,
  parameter logic [NUM_BAD*8-1:0] BAD_LIST = {8'hDB, 8'h42}
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          phi2,
  input  logic [AW-1:0] addr,
  input  logic          rw_n,
  input  logic          data_valid,
  input  logic          prog_valid,
  input  logic          filter_en,
  input  logic [7:0]    fetch_byte,
  output logic          ram_cs,
  output logic          rom_cs,
  output logic          io_cs,
  output logic          subst_en,
  output logic [7:0]    subst_byte,
  output logic          bad_fetch
);
  logic in_io, in_rom, in_ram;
  logic any_valid, op_fetch, wr;
  logic io_block, filter_hit;
  logic [NUM_BAD-1:0] hit;

  assign in_io  = addr[AW-1:IO_SPAN_BITS] == IO_BASE[AW-1:IO_SPAN_BITS];
  assign in_rom = !in_io && (addr[AW-1:ROM_SPAN_BITS] == ROM_BASE[AW-1:ROM_SPAN_BITS]);
  assign in_ram = !in_io && !in_rom;

  assign any_valid = data_valid | prog_valid;
  assign op_fetch  = data_valid & prog_valid;
  assign wr        = !rw_n;

  assign io_cs  = phi2 & in_io  & (wr | (data_valid & !prog_valid));
  assign rom_cs = phi2 & in_rom & (wr | any_valid);
  assign ram_cs = phi2 & in_ram & (wr | any_valid);

  for (genvar g = 0; g < NUM_BAD; g++) begin : g_match
    assign hit[g] = fetch_byte == BAD_LIST[g*8 +: 8];
  end

  assign io_block   = phi2 & rw_n & op_fetch & in_io;
  assign filter_hit = phi2 & rw_n & op_fetch & !in_io & filter_en & (|hit);

  assign subst_en   = io_block | filter_hit;
  assign subst_byte = io_block ? IO_FETCH_CODE : (filter_hit ? NOP_CODE : 8'h00);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          bad_fetch <= 1'b0;
    else if (filter_hit) bad_fetch <= 1'b1;
  end
endmodule

module bus_qualifier_chk (
  input logic clk,
  input logic rst_n,
  input logic phi2,
  input logic rw_n,
  input logic data_valid,
  input logic prog_valid,
  input logic ram_cs,
  input logic rom_cs,
  input logic io_cs,
  input logic subst_en,
  input logic bad_fetch
);
  p_internal_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rw_n && !data_valid && !prog_valid) |-> !(ram_cs || rom_cs || io_cs || subst_en));

  p_write_selects_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phi2 && !rw_n) |-> ($countones({ram_cs, rom_cs, io_cs}) == 1));

  p_io_read_data_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (io_cs && rw_n) |-> (data_valid && !prog_valid));

  p_no_io_fetch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rw_n && data_valid && prog_valid) |-> !io_cs);

  p_phi2_low_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !phi2 |-> !(ram_cs || rom_cs || io_cs || subst_en));

  p_one_region_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ram_cs, rom_cs, io_cs}));

  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bad_fetch |=> bad_fetch);
endmodule

bind bus_qualifier bus_qualifier_chk u_chk (
  .clk(clk), .rst_n(rst_n), .phi2(phi2), .rw_n(rw_n),
  .data_valid(data_valid), .prog_valid(prog_valid),
  .ram_cs(ram_cs), .rom_cs(rom_cs), .io_cs(io_cs),
  .subst_en(subst_en), .bad_fetch(bad_fetch)
);

// File: tb/bus_qualifier_test.sv
`timescale 1ns/1ps
module bus_qualifier_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic phi2 = 1'b0;
  logic [23:0] addr = '0;
  logic rw_n = 1'b1;
  logic dv = 1'b0, pv = 1'b0;
  logic fen = 1'b0;
  logic [7:0] fbyte = 8'h00;
  logic ram_cs, rom_cs, io_cs, subst_en, bad_fetch;
  logic [7:0] subst_byte;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit exp_flag = 0;

  typedef struct {
    logic [2:0] sels;
    logic       sub;
    logic [7:0] sbyte;
    logic       flag;
    int         req;
  } item_t;
  item_t q[$];

  always #2 clk = ~clk;

  bus_qualifier uut (
    .clk(clk), .rst_n(rst_n), .phi2(phi2), .addr(addr), .rw_n(rw_n),
    .data_valid(dv), .prog_valid(pv), .filter_en(fen), .fetch_byte(fbyte),
    .ram_cs(ram_cs), .rom_cs(rom_cs), .io_cs(io_cs),
    .subst_en(subst_en), .subst_byte(subst_byte), .bad_fetch(bad_fetch)
  );

  function automatic string rname(int r);
    case (r)
      1: return "R1"; 2: return "R2"; 3: return "R3"; 4: return "R4";
      5: return "R5"; 6: return "R6"; 7: return "R7"; 8: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic drive(input logic p, input logic [23:0] a, input logic r,
                       input logic d, input logic pr, input logic f,
                       input logic [7:0] b, input int req);
    item_t it;
    bit io, rom, fetch, blk, filt;
    @(negedge clk);
    phi2 = p; addr = a; rw_n = r; dv = d; pv = pr; fen = f; fbyte = b;
    io    = (a >= 24'h00D100) && (a <= 24'h00D1FF);
    rom   = (a >= 24'h00E000) && (a <= 24'h00FFFF);
    fetch = d && pr;
    it.sels = 3'b000;
    if (p && (!r || (io ? (d && !pr) : (d || pr))))
      it.sels = io ? 3'b001 : (rom ? 3'b010 : 3'b100);
    blk  = p && r && fetch && io;
    filt = p && r && fetch && !io && f && (b == 8'hDB || b == 8'h42);
    it.sub   = blk || filt;
    it.sbyte = blk ? 8'h00 : (filt ? 8'hEA : 8'h00);
    it.flag  = exp_flag;
    it.req   = req;
    q.push_back(it);
    if (filt) exp_flag = 1;
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(negedge clk);
      #1;
      if (q.size() > 0) begin
        it = q.pop_front();
        checks++;
        if ({ram_cs, rom_cs, io_cs} !== it.sels || subst_en !== it.sub ||
            subst_byte !== it.sbyte || bad_fetch !== it.flag) begin
          errors++;
          $display("FAIL %s addr=%h rw_n=%b flags=%b%b phi2=%b: got sel=%b sub=%b byte=%h flag=%b, want sel=%b sub=%b byte=%h flag=%b",
                   rname(it.req), addr, rw_n, dv, pv, phi2,
                   {ram_cs, rom_cs, io_cs}, subst_en, subst_byte, bad_fetch,
                   it.sels, it.sub, it.sbyte, it.flag);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got hung run, want completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; phi2 = 0; rw_n = 1; dv = 0; pv = 0; fen = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    exp_flag = 0;
  endtask

  logic [23:0] alist [9] = '{24'h001234, 24'h120000, 24'h00D0FF, 24'h00D100,
                             24'h00D1FF, 24'h00D200, 24'h00DFFF, 24'h00E000, 24'h00FFFF};

  initial begin : stim
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R9: reset state, flag low and nothing selected
    drive(0, 24'h00D100, 1, 0, 0, 0, 8'h00, 9);

    // Sweep of status code x direction x phi2 x region boundaries, filter off
    for (int fl = 0; fl < 4; fl++)
      for (int r = 0; r < 2; r++)
        for (int p = 0; p < 2; p++)
          for (int k = 0; k < 9; k++) begin
            int req;
            bit isio;
            isio = (alist[k] >= 24'h00D100) && (alist[k] <= 24'h00D1FF);
            if (p == 0) req = 6;
            else if (r == 0) req = (fl == 0) ? 2 : 7;
            else if (fl == 0) req = 1;
            else if (isio && fl == 3) req = 5;
            else if (isio) req = 3;
            else req = 4;
            drive(p[0], alist[k], r[0], fl[1], fl[0], 0, 8'hDB, req);
          end

    // R1: indexed dummy read 0x100 below the I/O target, then the real access
    drive(1, 24'h00D005, 1, 0, 0, 1, 8'h00, 1);
    drive(1, 24'h00D105, 1, 1, 0, 1, 8'h00, 3);

    // R8: filter off, allowed bytes, non-fetch and phi2-low cases substitute nothing
    drive(1, 24'h00E010, 1, 1, 1, 0, 8'h42, 8);
    drive(1, 24'h00E010, 1, 1, 1, 1, 8'hA9, 8);
    drive(0, 24'h00E010, 1, 1, 1, 1, 8'h42, 8);
    drive(1, 24'h00E010, 1, 1, 0, 1, 8'hDB, 8);
    drive(1, 24'h003000, 1, 0, 1, 1, 8'h42, 8);
    // R5 with filter on: I/O fetch forced to 0x00 and leaves the flag clear (R9)
    drive(1, 24'h00D120, 1, 1, 1, 1, 8'hDB, 5);
    drive(1, 24'h001000, 1, 0, 0, 1, 8'h00, 9);
    // R8: forbidden fetch from RAM, substituted with 0xEA
    drive(1, 24'h003000, 1, 1, 1, 1, 8'h42, 8);
    // R9: flag now set, stays set across benign cycles
    drive(1, 24'h00E000, 1, 1, 1, 1, 8'hDB, 8);
    drive(0, 24'h001000, 1, 0, 0, 0, 8'h00, 9);
    drive(1, 24'h001000, 0, 0, 0, 0, 8'h00, 9);
    drive(1, 24'h001000, 1, 1, 0, 0, 8'h00, 9);

    // R9: reset clears the sticky flag
    do_reset();
    drive(1, 24'h001000, 1, 1, 0, 0, 8'h00, 9);
    drive(1, 24'h00F000, 1, 1, 1, 1, 8'h00, 9);

    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule